// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 16 bits. The host hands it one word-sized read or write at a time over a request/ready handshake. The block turns each request into active-low chip-select, write-strobe, output-strobe and byte-lane strobes. It holds each strobe for enough clock cycles to meet the memory's minimum timing limits. Every phase length is worked out at elaboration time from a clock-period parameter in picoseconds: the limit is divided by the period and rounded up, with a floor of one cycle.

A write drives the data bus for the whole write-strobe pulse. The write always ends when the write strobe rises, and the controller stops driving the bus in that same cycle. A read holds the output strobe low until the access-time limit has passed, then captures the word and returns it with a one-cycle valid pulse. The chip is then kept deselected for a bus-release gap, so the controller never turns its drivers on while the memory's outputs may still be active. A request whose byte mask is zero finishes as a one-cycle no-operation and touches no strobe.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever no operation is in progress, `ready` is 1, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are all 1, and `sram_dout_en` is 0.
- R2: A request is taken on a rising edge where `req` and `ready` are both 1. The request fields are captured at that edge, and `ready` stays 0 from the next cycle until the operation and its trailing phase are over.
- R3: A read (`req_write`=0, mask nonzero) sets `sram_ce_n`=0, `sram_oe_n`=0, `sram_we_n`=1 and `sram_dout_en`=0 for N_RD = ceil(max(45 ns, 45 ns, 22 ns)/period) cycles, which is 12 at 4 ns. During those cycles `sram_addr` equals the captured address, `sram_lb_n` = not mask bit 0 (bits 7:0) and `sram_ub_n` = not mask bit 1 (bits 15:8).
- R4: At the edge that ends the read strobe, `sram_din` is captured into `rd_data`, and `rd_valid` is 1 for exactly the one following cycle.
- R5: After a read the chip is deselected (all strobes 1, `sram_dout_en`=0) and `ready` stays 0 for N_GAP = ceil(18 ns/period) cycles, which is 5 at 4 ns. `sram_dout_en` never rises until at least N_GAP cycles after `sram_oe_n` rose.
- R6: A write (`req_write`=1, mask nonzero) sets `sram_ce_n`=0, `sram_we_n`=0, `sram_oe_n`=1 and `sram_dout_en`=1, with `sram_dout` equal to the captured write data and the byte-lane strobes decoded as in R3. This lasts N_WP = ceil(max(35 ns, 35 ns, 25 ns)/period) cycles, which is 9 at 4 ns.
- R7: A write ends when `sram_we_n` rises, and `sram_dout_en` falls in that same cycle. `sram_ce_n` and the byte-lane strobes stay low for N_WREC = max(1, ceil(45 ns/period) - N_WP) recovery cycles, which is 3 at 4 ns, before the controller returns to idle.
- R8: A request with mask 0 keeps `ready` at 0 for one cycle, asserts no strobe, never drives the bus, gives no `rd_valid`, and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-cycle pulse with read data |
| sram_addr | output | 17 | Memory word address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_dout | output | 16 | Data driven to the memory bus |
| sram_dout_en | output | 1 | Bus driver enable |
| sram_din | input | 16 | Data sampled from the memory bus |

## Verification
The bench runs the following patterns:
- Full-word writes and reads, which check strobe ordering and phase lengths.
- Lower-only and upper-only writes followed by full reads, which show that each byte-lane strobe guards only its own half of the word.
- Single-lane reads, which check that the byte-lane strobes follow the read mask.
- Zero-mask writes and reads, which tell a true no-operation apart from one that still strobes the chip or changes memory.
- A read followed at once by a write, which exercises the bus-release gap before the drivers turn on.
- Accesses at the lowest and highest word addresses, which confirm that the full address width reaches the memory pins.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    // minimum timing limits of the memory, picoseconds
    localparam int LIM_RD_CYCLE_PS  = 45000;
    localparam int LIM_ADDR_ACC_PS  = 45000;
    localparam int LIM_OE_ACC_PS    = 22000;
    localparam int LIM_WR_CYCLE_PS  = 45000;
    localparam int LIM_WE_PULSE_PS  = 35000;
    localparam int LIM_ADDR_SU_PS   = 35000;
    localparam int LIM_DATA_SU_PS   = 25000;
    localparam int LIM_RELEASE_PS   = 18000;

    function automatic int ceil_cyc(int lim_ps, int per_ps);
        int c;
        c = (lim_ps + per_ps - 1) / per_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NOP,
        ST_RD,
        ST_RD_GAP,
        ST_WR,
        ST_WR_REC
    } ctl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
        logic dout_en;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                       ub_n: 1'b1, lb_n: 1'b1, dout_en: 1'b0};

    function automatic pin_set_t pins_for(ctl_state_e s, logic [1:0] m);
        pin_set_t p;
        p = PINS_IDLE;
        case (s)
            ST_RD: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
                p.ub_n = ~m[1];
                p.lb_n = ~m[0];
            end
            ST_WR: begin
                p.ce_n    = 1'b0;
                p.we_n    = 1'b0;
                p.ub_n    = ~m[1];
                p.lb_n    = ~m[0];
                p.dout_en = 1'b1;
            end
            ST_WR_REC: begin
                p.ce_n = 1'b0;
                p.ub_n = ~m[1];
                p.lb_n = ~m[0];
            end
            default: p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int N_RD   = 12,
    parameter int N_GAP  = 5,
    parameter int N_WP   = 9,
    parameter int N_WREC = 3,
    parameter int CW     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_write,
    input  logic [1:0] req_mask,
    output ctl_state_e state_q,
    output ctl_state_e state_d,
    output logic       accept,
    output logic       rd_last
);

    logic [CW-1:0] cnt_q, cnt_d;

    assign accept  = req && (state_q == ST_IDLE);
    assign rd_last = (state_q == ST_RD) && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_mask == 2'b00) begin
                        state_d = ST_NOP;
                    end else if (req_write) begin
                        state_d = ST_WR;
                        cnt_d   = CW'(N_WP - 1);
                    end else begin
                        state_d = ST_RD;
                        cnt_d   = CW'(N_RD - 1);
                    end
                end
            end
            ST_NOP: state_d = ST_IDLE;
            ST_RD: begin
                if (cnt_q == '0) begin
                    state_d = ST_RD_GAP;
                    cnt_d   = CW'(N_GAP - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RD_GAP: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_WR: begin
                if (cnt_q == '0) begin
                    state_d = ST_WR_REC;
                    cnt_d   = CW'(N_WREC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_REC: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R8
    nop_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NOP) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sramc_drive.sv
module sramc_drive
    import sramc_pkg::*;
#(
    parameter int AW    = 17,
    parameter int DW    = 16,
    parameter int N_GAP = 5,
    parameter int N_WP  = 9,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          idle,
    input  ctl_state_e    state_q,
    input  ctl_state_e    state_d,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dout,
    output pin_set_t      pins
);

    logic [1:0] mask_q, mask_sel;

    assign mask_sel = accept ? req_mask : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            sram_addr <= '0;
            sram_dout <= '0;
            pins      <= PINS_IDLE;
        end else begin
            if (accept) begin
                mask_q    <= req_mask;
                sram_addr <= req_addr;
                sram_dout <= req_wdata;
            end
            pins <= pins_for(state_d, mask_sel);
        end
    end

    // observation counters for the timing checks below
    logic [CW:0] we_lo_cnt, oe_hi_cnt;
    localparam logic [CW:0] CNT_SAT = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= CNT_SAT;
        end else begin
            if (pins.we_n)                we_lo_cnt <= '0;
            else if (we_lo_cnt != CNT_SAT) we_lo_cnt <= we_lo_cnt + 1'b1;
            if (!pins.oe_n)               oe_hi_cnt <= '0;
            else if (oe_hi_cnt != CNT_SAT) oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (pins.ce_n && pins.we_n && pins.oe_n && !pins.dout_en));

    // R3
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.oe_n |-> pins.we_n);

    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.dout_en) |-> (oe_hi_cnt >= (CW+1)'(N_GAP)));

    // R6
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.we_n) |-> (we_lo_cnt >= (CW+1)'(N_WP)));

    // R7
    end_on_we_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.we_n) |-> (!pins.ce_n && !pins.dout_en));

    // R8
    nop_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NOP) |-> (pins.ce_n && !pins.dout_en));

endmodule

// File: rtl/sramc_rdcap.sv
module sramc_rdcap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_last,
    input  logic [DW-1:0] sram_din,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_last;
            if (rd_last) rd_data <= sram_din;
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int CLK_PS      = 4000,
    parameter int AW          = 17,
    parameter int DW          = 16,
    parameter int RD_CYCLE_PS = LIM_RD_CYCLE_PS,
    parameter int ADDR_ACC_PS = LIM_ADDR_ACC_PS,
    parameter int OE_ACC_PS   = LIM_OE_ACC_PS,
    parameter int WR_CYCLE_PS = LIM_WR_CYCLE_PS,
    parameter int WE_PULSE_PS = LIM_WE_PULSE_PS,
    parameter int ADDR_SU_PS  = LIM_ADDR_SU_PS,
    parameter int DATA_SU_PS  = LIM_DATA_SU_PS,
    parameter int RELEASE_PS  = LIM_RELEASE_PS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    output logic          ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic          sram_ub_n,
    output logic          sram_lb_n,
    output logic [DW-1:0] sram_dout,
    output logic          sram_dout_en,
    input  logic [DW-1:0] sram_din
);

    localparam int N_RD   = ceil_cyc(imax(RD_CYCLE_PS, imax(ADDR_ACC_PS, OE_ACC_PS)), CLK_PS);
    localparam int N_GAP  = ceil_cyc(RELEASE_PS, CLK_PS);
    localparam int N_WP   = ceil_cyc(imax(WE_PULSE_PS, imax(ADDR_SU_PS, DATA_SU_PS)), CLK_PS);
    localparam int N_WREC = imax(1, ceil_cyc(WR_CYCLE_PS, CLK_PS) - N_WP);
    localparam int N_MAX  = imax(imax(N_RD, N_GAP), imax(N_WP, N_WREC));
    localparam int CW     = $clog2(N_MAX + 1);

    ctl_state_e state_q, state_d;
    logic       accept, rd_last;
    pin_set_t   pins;

    assign ready = (state_q == ST_IDLE);

    sramc_seq #(
        .N_RD(N_RD), .N_GAP(N_GAP), .N_WP(N_WP), .N_WREC(N_WREC), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_mask(req_mask), .state_q(state_q), .state_d(state_d),
        .accept(accept), .rd_last(rd_last)
    );

    sramc_drive #(
        .AW(AW), .DW(DW), .N_GAP(N_GAP), .N_WP(N_WP), .CW(CW)
    ) u_drive (
        .clk(clk), .rst(rst), .accept(accept), .idle(ready),
        .state_q(state_q), .state_d(state_d), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .sram_addr(sram_addr), .sram_dout(sram_dout), .pins(pins)
    );

    sramc_rdcap #(.DW(DW)) u_rdcap (
        .clk(clk), .rst(rst), .rd_last(rd_last), .sram_din(sram_din),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign sram_ce_n    = pins.ce_n;
    assign sram_we_n    = pins.we_n;
    assign sram_oe_n    = pins.oe_n;
    assign sram_ub_n    = pins.ub_n;
    assign sram_lb_n    = pins.lb_n;
    assign sram_dout_en = pins.dout_en;

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

    // phase lengths from the requirements at a 4 ns clock
    localparam int RD_CYC   = (45 + 3) / 4;
    localparam int GAP_CYC  = (18 + 3) / 4;
    localparam int WP_CYC   = (35 + 3) / 4;
    localparam int WREC_CYC = (45 + 3) / 4 - WP_CYC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        ready, rd_valid;
    logic [15:0] rd_data;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
    logic [15:0] sram_dout, sram_din;
    logic        sram_dout_en;

    always #2 clk = ~clk;

    sram_async_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dout(sram_dout), .sram_dout_en(sram_dout_en), .sram_din(sram_din)
    );

    // behavioural memory on the far side of the pins
    logic [15:0] mem [0:7];
    initial for (int i = 0; i < 8; i++) mem[i] = 16'h0000;

    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0) begin
            if (sram_lb_n === 1'b0) mem[sram_addr[2:0]][7:0]  <= sram_dout[7:0];
            if (sram_ub_n === 1'b0) mem[sram_addr[2:0]][15:8] <= sram_dout[15:8];
        end
    end

    always_comb begin
        sram_din = 16'h0000;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            if (!sram_lb_n) sram_din[7:0]  = mem[sram_addr[2:0]][7:0];
            if (!sram_ub_n) sram_din[15:8] = mem[sram_addr[2:0]][15:8];
        end
    end

    // reference model
    typedef struct {
        logic [5:0]  pins;    // ce we oe ub lb den
        logic        rdy;
        logic        vld;
        logic [15:0] data;
        logic [15:0] lanes;
        logic        chk_addr;
        logic [16:0] addr;
        logic        chk_dout;
        logic [15:0] dout;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] gold [0:7];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic        run = 1'b0;

    initial for (int i = 0; i < 8; i++) gold[i] = 16'h0000;

    function automatic exp_t mk(logic [5:0] p, string t);
        exp_t e;
        e.pins = p; e.rdy = 1'b0; e.vld = 1'b0; e.data = '0; e.lanes = '0;
        e.chk_addr = 1'b0; e.addr = '0; e.chk_dout = 1'b0; e.dout = '0;
        e.tag = t;
        return e;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_op(logic w, logic [16:0] a, logic [15:0] d, logic [1:0] m);
        exp_t e;
        logic ub, lb;
        ub = ~m[1]; lb = ~m[0];
        if (m == 2'b00) begin
            // R8: one busy cycle, idle pins
            q.push_back(mk(6'b111110, "R8"));
        end else if (!w) begin
            for (int i = 0; i < RD_CYC; i++) begin
                e = mk({1'b0, 1'b1, 1'b0, ub, lb, 1'b0}, "R3");
                e.chk_addr = 1'b1; e.addr = a;
                q.push_back(e);
            end
            for (int i = 0; i < GAP_CYC; i++) begin
                e = mk(6'b111110, (i == 0) ? "R4" : "R5");
                if (i == 0) begin
                    e.vld = 1'b1;
                    e.data = gold[a[2:0]];
                    e.lanes = {{8{m[1]}}, {8{m[0]}}};
                end
                q.push_back(e);
            end
        end else begin
            for (int i = 0; i < WP_CYC; i++) begin
                e = mk({1'b0, 1'b0, 1'b1, ub, lb, 1'b1}, "R6");
                e.chk_addr = 1'b1; e.addr = a;
                e.chk_dout = 1'b1; e.dout = d;
                q.push_back(e);
            end
            for (int i = 0; i < WREC_CYC; i++) begin
                e = mk({1'b0, 1'b1, 1'b1, ub, lb, 1'b0}, "R7");
                e.chk_addr = 1'b1; e.addr = a;
                q.push_back(e);
            end
            if (m[0]) gold[a[2:0]][7:0]  = d[7:0];
            if (m[1]) gold[a[2:0]][15:8] = d[15:8];
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            exp_t e;
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e = mk(6'b111110, "R1");
                e.rdy = 1'b1;
            end
            chk(e.tag, "pins", {26'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n,
                                sram_lb_n, sram_dout_en}, {26'd0, e.pins});
            chk(e.rdy ? e.tag : "R2", "ready", {31'd0, ready}, {31'd0, e.rdy});
            chk(e.tag, "rd_valid", {31'd0, rd_valid}, {31'd0, e.vld});
            if (e.vld)
                chk(e.tag, "rd_data", {16'd0, rd_data & e.lanes}, {16'd0, e.data & e.lanes});
            if (e.chk_addr)
                chk(e.tag, "addr", {15'd0, sram_addr}, {15'd0, e.addr});
            if (e.chk_dout)
                chk(e.tag, "dout", {16'd0, sram_dout}, {16'd0, e.dout});
            if (e.rdy && req) push_op(req_write, req_addr, req_wdata, req_mask);
        end
    end

    task automatic op(logic w, logic [16:0] a, logic [15:0] d, logic [1:0] m);
        @(posedge clk);
        #1;
        req = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        do @(negedge clk); while (!ready);
        @(posedge clk);
        #1;
        req = 1'b0;
        req_wdata = 16'hDEAD;
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state while reset is held
        chk("R1", "reset pins", {26'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n,
                                 sram_lb_n, sram_dout_en}, 32'h3E);
        chk("R1", "reset rd_valid", {31'd0, rd_valid}, 32'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        run = 1'b1;
        repeat (3) @(posedge clk);

        op(1'b1, 17'h00005, 16'h1234, 2'b11);   // R6 R7 full write
        op(1'b0, 17'h00005, 16'h0000, 2'b11);   // R3 R4 R5 full read
        op(1'b1, 17'h00005, 16'hABCD, 2'b01);   // lower lane only
        op(1'b0, 17'h00005, 16'h0000, 2'b11);   // expect 12CD
        op(1'b1, 17'h00005, 16'h77EE, 2'b10);   // upper lane only
        op(1'b0, 17'h00005, 16'h0000, 2'b10);   // upper-lane read
        op(1'b0, 17'h00005, 16'h0000, 2'b01);   // lower-lane read
        op(1'b1, 17'h00005, 16'hFFFF, 2'b00);   // R8 zero-mask write
        op(1'b0, 17'h00005, 16'h0000, 2'b11);   // still 77CD
        op(1'b0, 17'h00005, 16'h0000, 2'b00);   // R8 zero-mask read
        op(1'b0, 17'h00005, 16'h0000, 2'b11);   // read then write: turnaround
        op(1'b1, 17'h1FFFF, 16'h5AA5, 2'b11);   // top address
        op(1'b1, 17'h00000, 16'hC33C, 2'b11);   // bottom address
        op(1'b0, 17'h1FFFF, 16'h0000, 2'b11);
        op(1'b0, 17'h00000, 16'h0000, 2'b11);
        op(1'b1, 17'h0000A, 16'h0F0F, 2'b11);
        op(1'b1, 17'h0000A, 16'hF000, 2'b10);   // back-to-back writes
        op(1'b0, 17'h0000A, 16'h0000, 2'b11);   // expect F00F

        repeat (40) @(posedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule